// File: doc/BRIEF.md
# Event Counter Timer with Prescaler

This block counts active edges on an external event pin through two cascaded down-counters. An 8-bit prescaler stage takes the events. Each time the prescaler wraps, the 8-bit main stage steps once. Each stage reloads from its own reload register when it passes zero, and counting then continues without a pause. With prescaler setting n and main setting m, one underflow of the main stage occurs every (n+1)(m+1) active edges. Each underflow raises a one-cycle interrupt strobe and can invert a pulse output pin.

The event pin passes through a two-flop synchronizer. It can then go through a sampling digital filter whose sampling period is selectable. The edge detector picks the rising or the falling transition. A gate input can restrict the times at which edges are counted. Software uses a small write/read register port. It loads the two stage values, starts, pauses or force-stops the count, selects the mode bits and reads back the live counts at any time.

Run control is a two-state machine:
- STOP: the counters hold their values.
- RUN: active edges are counted.

Transitions:
- STOP to RUN: a control write with the start bit set and the force-stop bit clear.
- RUN to STOP: a control write with the start bit clear (a pause), or any control write with the force-stop bit set.

Top module: `evt_timer`

## Requirements
- R1: After reset every readback address returns 0, `irq` and `pulse_out` are low, and the machine is in STOP.
- R2: Mode bit 0 selects the active edge: 0 counts rising transitions of the event input, and 1 counts falling transitions. The other transition has no effect.
- R3: Counting is downward. On an active edge the prescaler decrements, or reloads if it is 0. When the prescaler reloads, the main stage decrements, or reloads if it is 0. A main-stage reload is one underflow, so underflows occur once every (n+1)(m+1) active edges.
- R4: A control write (address 0) with bit 0 = 1 enters RUN. A control write with bit 0 = 0 pauses in STOP. While in STOP, edges leave both live counts unchanged.
- R5: A control write with bit 1 = 1 enters STOP at once and copies both reload registers into the live counters.
- R6: A write to the prescaler (address 2) or main (address 3) register in RUN updates the reload register at once. The live counter takes the new value at the next counted edge. That edge decrements no stage and causes no underflow.
- R7: A write to address 2 or 3 in STOP updates both the reload register and the live counter, and the readback shows the new value in the next cycle.
- R8: `irq` is high for exactly one cycle per main-stage underflow. With the filter off, it is high in the cycle after the third rising clock edge that follows the change on the event pin.
- R9: With mode bit 1 set, `pulse_out` inverts on every underflow. It never changes otherwise, and a mode write does not change its level.
- R10: Mode bit 2 enables the filter. Mode bits 4:3 select a sampling period of 1, 4, 16 or 64 cycles. A new level passes only after three consecutive equal samples. At period 1, a counted edge gives `irq` four cycles later than in R8, and a pulse lasting two cycles is rejected.
- R11: Mode bits 6:5 select gating: 0 counts always, 1 counts only while `gate_in` is high, 2 counts only while `gate_in` is low, and 3 counts nothing.
- R12: Readback map: address 0 returns the run flag in bit 0, address 1 returns the mode register, address 2 returns the live prescaler count, and address 3 returns the live main count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register address for write and readback |
| wr_data | input | CW | Write data |
| rd_data | output | CW | Readback of the register at `addr`, combinational |
| event_in | input | 1 | External event input |
| gate_in | input | 1 | Gate level used by the gating modes |
| irq | output | 1 | One-cycle strobe on a main-stage underflow |
| pulse_out | output | 1 | Level that inverts on each underflow when enabled |

## Verification
With the filter off, an event edge driven just after a falling clock edge produces its underflow strobe after the third rising edge. At filter period 1 the strobe comes after the seventh rising edge. Register writes show in readback one cycle after the strobe. For each edge that should cause an underflow, the driver pushes the due cycle number into a queue. At every falling edge the monitor pops one entry for each strobe and compares the current cycle with it. The monitor flags any strobe for which no entry was queued, and the bench flags any entry still queued at the end. The only exception is the long filter period, where the sample phase makes the exact cycle uncertain; for that case the driver queues a wildcard entry. Readback and `pulse_out` are sampled one nanosecond after a falling edge, once all updates from the preceding rising edge have settled.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_MODE = 2'd1,
        A_PRE  = 2'd2,
        A_MAIN = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        GATE_OPEN = 2'd0,
        GATE_HIGH = 2'd1,
        GATE_LOW  = 2'd2,
        GATE_SHUT = 2'd3
    } gate_mode_e;

    // bit 0 edge, bit 1 output enable, bit 2 filter, bits 4:3 rate, bits 6:5 gate
    typedef struct packed {
        logic [1:0] gate;
        logic [1:0] rate;
        logic       filt_en;
        logic       out_en;
        logic       fall_edge;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/evt_input_filter.sv
module evt_input_filter #(
    parameter int DIVW  = 6,
    parameter int NSAMP = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw,
    input  logic       filt_en,
    input  logic [1:0] rate,
    output logic       level
);
    logic [1:0]       sync_q;
    logic [DIVW-1:0]  div_q;
    logic [DIVW-1:0]  mask;
    logic [NSAMP-1:0] samp_q;
    logic             filt_q;
    logic             tick;

    always_comb begin
        mask = DIVW'((32'd1 << (2 * rate)) - 32'd1);
        tick = (div_q & mask) == '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            div_q  <= '0;
            samp_q <= '0;
            filt_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw};
            div_q  <= div_q + 1'b1;
            if (tick)
                samp_q <= {samp_q[NSAMP-2:0], sync_q[1]};
            if (&samp_q)
                filt_q <= 1'b1;
            else if (~|samp_q)
                filt_q <= 1'b0;
        end
    end

    assign level = filt_en ? filt_q : sync_q[1];

endmodule

// File: rtl/evt_edge_gate.sv
module evt_edge_gate
    import evt_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  logic       fall_edge,
    input  logic       gate_raw,
    input  logic [1:0] gate_mode,
    output logic       cnt_evt
);
    logic       prev_q;
    logic [1:0] gsync_q;
    logic       hit;
    logic       allow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            gsync_q <= '0;
        end else begin
            prev_q  <= level;
            gsync_q <= {gsync_q[0], gate_raw};
        end
    end

    always_comb begin
        hit = fall_edge ? (prev_q & ~level) : (level & ~prev_q);
        unique case (gate_mode_e'(gate_mode))
            GATE_OPEN: allow = 1'b1;
            GATE_HIGH: allow = gsync_q[1];
            GATE_LOW:  allow = ~gsync_q[1];
            GATE_SHUT: allow = 1'b0;
        endcase
        cnt_evt = hit & allow;
    end

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
    import evt_timer_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_evt,
    input  logic          ctrl_wr,
    input  logic          start_val,
    input  logic          stop_force,
    input  logic          pre_wr,
    input  logic          main_wr,
    input  logic [CW-1:0] wr_val,
    input  logic          out_en,
    output logic          running,
    output logic          irq,
    output logic          pulse_out,
    output logic [CW-1:0] pre_cnt,
    output logic [CW-1:0] main_cnt,
    output logic [CW-1:0] pre_rld,
    output logic [CW-1:0] main_rld
);
    run_state_e state_q, state_d;
    logic       pend_pre, pend_main;
    logic       out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (ctrl_wr && start_val && !stop_force) state_d = ST_RUN;
            ST_RUN:  if (stop_force || (ctrl_wr && !start_val)) state_d = ST_STOP;
        endcase
    end

    always_comb begin
        running   = (state_q == ST_RUN);
        pulse_out = out_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt   <= '0;
            main_cnt  <= '0;
            pre_rld   <= '0;
            main_rld  <= '0;
            pend_pre  <= 1'b0;
            pend_main <= 1'b0;
            irq       <= 1'b0;
            out_q     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (pre_wr)  pre_rld  <= wr_val;
            if (main_wr) main_rld <= wr_val;
            if (stop_force) begin
                pre_cnt   <= pre_rld;
                main_cnt  <= main_rld;
                pend_pre  <= 1'b0;
                pend_main <= 1'b0;
            end else if (state_q == ST_STOP) begin
                if (pre_wr) begin
                    pre_cnt  <= wr_val;
                    pend_pre <= 1'b0;
                end
                if (main_wr) begin
                    main_cnt  <= wr_val;
                    pend_main <= 1'b0;
                end
            end else begin
                if (cnt_evt) begin
                    if (pend_pre || pend_main) begin
                        if (pend_pre)  pre_cnt  <= pre_rld;
                        if (pend_main) main_cnt <= main_rld;
                        pend_pre  <= 1'b0;
                        pend_main <= 1'b0;
                    end else if (pre_cnt == '0) begin
                        pre_cnt <= pre_rld;
                        if (main_cnt == '0) begin
                            main_cnt <= main_rld;
                            irq      <= 1'b1;
                            if (out_en) out_q <= ~out_q;
                        end else begin
                            main_cnt <= main_cnt - 1'b1;
                        end
                    end else begin
                        pre_cnt <= pre_cnt - 1'b1;
                    end
                end
                if (pre_wr)  pend_pre  <= 1'b1;
                if (main_wr) pend_main <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CW    = 8,
    parameter int DIVW  = 6,
    parameter int NSAMP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] rd_data,
    input  logic          event_in,
    input  logic          gate_in,
    output logic          irq,
    output logic          pulse_out
);
    mode_t         mode_q;
    logic          level;
    logic          cnt_evt;
    logic          running;
    logic          ctrl_wr, pre_wr, main_wr, mode_wr;
    logic [CW-1:0] pre_cnt, main_cnt, pre_rld, main_rld;
    logic          unused_hi_bits;

    assign unused_hi_bits = ^wr_data[CW-1:MODE_W];

    always_comb begin
        ctrl_wr = wr_en && (reg_addr_e'(addr) == A_CTRL);
        mode_wr = wr_en && (reg_addr_e'(addr) == A_MODE);
        pre_wr  = wr_en && (reg_addr_e'(addr) == A_PRE);
        main_wr = wr_en && (reg_addr_e'(addr) == A_MAIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= mode_t'(wr_data[MODE_W-1:0]);
    end

    evt_input_filter #(.DIVW(DIVW), .NSAMP(NSAMP)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (event_in),
        .filt_en (mode_q.filt_en),
        .rate    (mode_q.rate),
        .level   (level)
    );

    evt_edge_gate u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (level),
        .fall_edge (mode_q.fall_edge),
        .gate_raw  (gate_in),
        .gate_mode (mode_q.gate),
        .cnt_evt   (cnt_evt)
    );

    evt_count_core #(.CW(CW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_evt    (cnt_evt),
        .ctrl_wr    (ctrl_wr),
        .start_val  (wr_data[0]),
        .stop_force (ctrl_wr && wr_data[1]),
        .pre_wr     (pre_wr),
        .main_wr    (main_wr),
        .wr_val     (wr_data),
        .out_en     (mode_q.out_en),
        .running    (running),
        .irq        (irq),
        .pulse_out  (pulse_out),
        .pre_cnt    (pre_cnt),
        .main_cnt   (main_cnt),
        .pre_rld    (pre_rld),
        .main_rld   (main_rld)
    );

    always_comb begin
        unique case (reg_addr_e'(addr))
            A_CTRL: rd_data = {{(CW-1){1'b0}}, running};
            A_MODE: rd_data = CW'(mode_q);
            A_PRE:  rd_data = pre_cnt;
            A_MAIN: rd_data = main_cnt;
        endcase
    end

endmodule

// File: rtl/evt_timer_checker.sv
module evt_timer_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    addr,
    input logic [CW-1:0] wr_data,
    input logic          irq,
    input logic          pulse_out,
    input logic          running,
    input logic [CW-1:0] pre_cnt,
    input logic [CW-1:0] main_cnt,
    input logic [CW-1:0] pre_rld,
    input logic [CW-1:0] main_rld
);
    // R8: the strobe lasts a single cycle
    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8: an underflow strobe only follows a running cycle
    a_r8_irq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(running));

    // R9: the output level moves only together with an underflow
    a_r9_pulse_only_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out != $past(pulse_out)) |-> irq);

    // R4: stopped with no write, the live counts hold
    a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(running) && !$past(wr_en)) |-> ($stable(pre_cnt) && $stable(main_cnt)));

    // R5: forced stop leaves STOP with both reload values in place
    a_r5_force_reload: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == 2'd0 && wr_data[1]) |->
            (!running && pre_cnt == $past(pre_rld) && main_cnt == $past(main_rld)));

endmodule

bind evt_timer evt_timer_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .irq       (irq),
    .pulse_out (pulse_out),
    .running   (running),
    .pre_cnt   (pre_cnt),
    .main_cnt  (main_cnt),
    .pre_rld   (pre_rld),
    .main_rld  (main_rld)
);

// File: tb/evt_timer_bench.sv
`timescale 1ns/1ps
module evt_timer_bench;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] rd_data;
    logic          event_in = 1'b0;
    logic          gate_in = 1'b0;
    logic          irq;
    logic          pulse_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int exp_q[$];

    evt_timer #(.CW(CW)) u_evt_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .event_in(event_in),
        .gate_in(gate_in), .irq(irq), .pulse_out(pulse_out)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        chk("R8 pending underflows left", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // scoreboard monitor: each strobe consumes one expected cycle (-1 = any)
    always @(negedge clk) begin
        if (rst_n && irq) begin
            if (exp_q.size() == 0) chk("R8 unexpected irq", cyc, -2);
            else begin
                automatic int e = exp_q.pop_front();
                if (e >= 0) chk("R8 irq cycle", cyc, e);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
        @(negedge clk);
        addr = a;
        #1 chk(req, int'(rd_data), exp);
    endtask

    // one pulse on event_in; at_fall says which transition is the active one
    task automatic ev(input bit expect_irq, input int lat, input bit at_fall, input int hold);
        @(negedge clk);
        event_in = 1'b1;
        if (expect_irq && !at_fall) exp_q.push_back(lat < 0 ? -1 : cyc + lat);
        repeat (hold) @(negedge clk);
        event_in = 1'b0;
        if (expect_irq && at_fall) exp_q.push_back(lat < 0 ? -1 : cyc + lat);
        repeat (hold) @(negedge clk);
    endtask

    task automatic glitch(input int len);
        @(negedge clk);
        event_in = 1'b1;
        repeat (len) @(negedge clk);
        event_in = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 ctrl", 2'd0, 0);
        rd_chk("R1 mode", 2'd1, 0);
        rd_chk("R1 pre", 2'd2, 0);
        rd_chk("R1 main", 2'd3, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 pulse_out", int'(pulse_out), 0);

        // R7 stopped writes land at once; R12 map
        wr(2'd1, 8'h02);
        rd_chk("R12 mode readback", 2'd1, 2);
        wr(2'd2, 8'd2);
        rd_chk("R7 pre", 2'd2, 2);
        wr(2'd3, 8'd1);
        rd_chk("R7 main", 2'd3, 1);

        // R4 start; R3 ratio (2+1)(1+1)=6
        wr(2'd0, 8'h01);
        rd_chk("R4 running flag", 2'd0, 1);
        repeat (3) ev(0, 0, 0, 12);
        rd_chk("R3 pre after 3", 2'd2, 2);
        rd_chk("R3 main after 3", 2'd3, 0);
        repeat (2) ev(0, 0, 0, 12);
        ev(1, 3, 0, 12);
        chk("R9 pulse after 1st underflow", int'(pulse_out), 1);
        rd_chk("R3 main reloaded", 2'd3, 1);
        repeat (5) ev(0, 0, 0, 12);
        ev(1, 3, 0, 12);
        chk("R9 pulse after 2nd underflow", int'(pulse_out), 0);

        // R4 pause holds counts
        wr(2'd0, 8'h00);
        rd_chk("R4 paused flag", 2'd0, 0);
        repeat (3) ev(0, 0, 0, 12);
        rd_chk("R4 pre held", 2'd2, 2);
        rd_chk("R4 main held", 2'd3, 1);

        // R6 write while running applies at the next counted edge
        wr(2'd0, 8'h01);
        ev(0, 0, 0, 12);
        rd_chk("R3 pre decrement", 2'd2, 1);
        wr(2'd2, 8'd0);
        rd_chk("R6 pre not yet loaded", 2'd2, 1);
        ev(0, 0, 0, 12);
        rd_chk("R6 pre loaded at edge", 2'd2, 0);
        rd_chk("R6 main untouched", 2'd3, 1);
        ev(0, 0, 0, 12);
        ev(1, 3, 0, 12);
        chk("R9 pulse after 3rd underflow", int'(pulse_out), 1);
        ev(0, 0, 0, 12);
        rd_chk("R3 main stepped", 2'd3, 0);

        // R5 forced stop reloads live counts
        wr(2'd0, 8'h02);
        rd_chk("R5 stopped", 2'd0, 0);
        rd_chk("R5 pre reloaded", 2'd2, 0);
        rd_chk("R5 main reloaded", 2'd3, 1);
        ev(0, 0, 0, 12);
        rd_chk("R5 main held after stop", 2'd3, 1);

        // R2 falling edge select, n=m=0
        wr(2'd3, 8'd0);
        wr(2'd1, 8'h03);
        chk("R9 mode write keeps level", int'(pulse_out), 1);
        wr(2'd0, 8'h01);
        ev(1, 3, 1, 12);
        chk("R2 pulse after falling count", int'(pulse_out), 0);

        // R11 gating
        wr(2'd1, 8'h22);
        ev(0, 0, 0, 12);
        gate_in = 1'b1;
        repeat (4) @(negedge clk);
        ev(1, 3, 0, 12);
        wr(2'd1, 8'h42);
        ev(0, 0, 0, 12);
        wr(2'd1, 8'h62);
        ev(0, 0, 0, 12);
        rd_chk("R11 main after gating", 2'd3, 0);

        // R10 filter at period 1 and period 4
        wr(2'd1, 8'h06);
        glitch(2);
        ev(1, 7, 0, 12);
        wr(2'd1, 8'h0E);
        glitch(5);
        ev(1, -1, 0, 30);
        chk("R10 filtered underflows consumed", exp_q.size(), 0);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule